// File: doc/BRIEF.md
# Chip-Select Static Memory Controller

This block sits between a host request port and an external static memory bus with four chip-select lines. Each region has an 8-bit configuration register that sets its access length (wait-state code), a synchronous/asynchronous mode flag, a write-enable bit and a data-width code. The registers sit behind a small byte-addressed register port. A key register guards them: until the key value is written, configuration writes are dropped.

The host issues one read or write at a time and names the target region by index. The controller asserts that region's chip select and the matching output-enable or write-enable strobe for the number of cycles its wait code calls for. It then returns a one-cycle response with the read data and the region's effective data width. A write to a region whose write-enable bit is clear never reaches the bus and returns an error response.

Top module: `xmem_ctrl`

## Requirements
- R1: After reset the guard is locked (key register reads 0), every configuration register reads 0x00F2, all chip selects and both strobes are high, req_ready is 1 and rsp_valid is 0.
- R2: A register-port write of 0xA05F to byte offset 0x20 unlocks the guard, and reading 0x20 then returns 1 in bit 0. A write of any other value to 0x20 locks it again, and the read returns 0.
- R3: While locked, a write to a configuration offset leaves that register's readback value unchanged.
- R4: While unlocked, a write to offset 4*i (i = 0..3) stores write-data bits 7:0 into region i's register. Readback returns them in bits 7:0 with bits 15:8 reading 0.
- R5: An accepted access holds its chip select low for exactly min(code + 2, 16) consecutive cycles, where code is register bits 7:4. Codes 14 and 15 both give 16 cycles.
- R6: During an access only the addressed chip select is low. Reads hold mem_oe_n low and mem_we_n high, writes do the reverse, and mem_addr (and mem_wdata for writes) stay constant. With no access both strobes are high.
- R7: rsp_valid pulses in the cycle after the last strobe cycle with rsp_err = 0. For reads, rsp_rdata carries mem_rdata as sampled in the last strobe cycle; for writes it is 0.
- R8: A write to a region whose register bit 2 is 0 drives no chip select or strobe and raises rsp_valid with rsp_err = 1 in the cycle after acceptance. Reads of such a region proceed normally.
- R9: rsp_width reports register bits 1:0 of the accessed region (00 = 8-bit, 01 = 16-bit, 10 = 32-bit). The reserved code 11 is reported as 10.
- R10: mem_sync equals register bit 3 of the active region (1 = synchronous) while its strobe is active, and is 0 when the bus is idle.
- R11: req_ready is 1 only when no access is in progress. A request presented while busy is ignored and does not disturb the running access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Register port write strobe |
| cfg_addr | input | CFG_AW | Register port byte offset |
| cfg_wdata | input | 16 | Register port write data |
| cfg_rdata | output | 16 | Register port read data for cfg_addr |
| req_valid | input | 1 | Host request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_cs | input | log2(NUM_CS) | Target region index |
| req_addr | input | ADDR_W | External address |
| req_wdata | input | DATA_W | Write data |
| req_ready | output | 1 | Controller idle, request accepted this cycle |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_err | output | 1 | Response is a refused write |
| rsp_rdata | output | DATA_W | Read data |
| rsp_width | output | 2 | Effective data width of the region |
| mem_cs_n | output | NUM_CS | Active-low chip selects |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_we_n | output | 1 | Active-low write enable |
| mem_sync | output | 1 | Synchronous-mode flag of the active region |
| mem_addr | output | ADDR_W | External address |
| mem_wdata | output | DATA_W | External write data |
| mem_rdata | input | DATA_W | External read data |

## Verification
The bench builds the controller with its defaults: four regions and a 16-cycle ceiling. With those values the saturating wait codes 14 and 15 and the shortest 2-cycle access can all be reached, and every chip-select line gets exercised. Random configuration values cover all four width codes, including the reserved one, and both mode-flag and write-enable settings. Random lock-key writes switch the guard between locked and unlocked over the run.

// File: rtl/xmem_pkg.sv
package xmem_pkg;
    localparam int CFG_W  = 8;
    localparam int WAIT_W = 4;
    localparam int KEY_W  = 16;
    localparam logic [CFG_W-1:0] CFG_RST    = 8'hF2;
    localparam logic [KEY_W-1:0] UNLOCK_KEY = 16'hA05F;

    // field layout of one region register: wait[7:4] sync[3] wen[2] width[1:0]
    typedef struct packed {
        logic [WAIT_W-1:0] wait_code;
        logic              sync;
        logic              wen;
        logic [1:0]        width;
    } cfg_t;

    function automatic logic [1:0] eff_width(input logic [1:0] code);
        return (code == 2'b11) ? 2'b10 : code;
    endfunction
endpackage

// File: rtl/xmem_cfg_bank.sv
module xmem_cfg_bank
    import xmem_pkg::*;
#(
    parameter int NUM_CS   = 4,
    parameter int CFG_AW   = 6,
    parameter int LOCK_OFF = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_wr,
    input  logic [CFG_AW-1:0]     cfg_addr,
    input  logic [KEY_W-1:0]      cfg_wdata,
    output logic [KEY_W-1:0]      cfg_rdata,
    output cfg_t [NUM_CS-1:0]     cfg_out
);
    typedef struct packed {
        cfg_t [NUM_CS-1:0] regs;
        logic              unlocked;
    } bank_t;

    bank_t d, q;
    logic [NUM_CS-1:0] sel;
    logic              lock_hit;

    for (genvar i = 0; i < NUM_CS; i++) begin : g_dec
        assign sel[i] = (cfg_addr == CFG_AW'(i * 4));
    end
    assign lock_hit = (cfg_addr == CFG_AW'(LOCK_OFF));

    always_comb begin
        d = q;
        if (cfg_wr && lock_hit) begin
            d.unlocked = (cfg_wdata == UNLOCK_KEY);
        end
        for (int i = 0; i < NUM_CS; i++) begin
            if (cfg_wr && sel[i] && q.unlocked) begin
                d.regs[i] = cfg_t'(cfg_wdata[CFG_W-1:0]);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= {{NUM_CS{CFG_RST}}, 1'b0};
        end else begin
            q <= d;
        end
    end

    always_comb begin
        cfg_rdata = '0;
        for (int i = 0; i < NUM_CS; i++) begin
            if (sel[i]) cfg_rdata = {{(KEY_W-CFG_W){1'b0}}, q.regs[i]};
        end
        if (lock_hit) cfg_rdata = {{(KEY_W-1){1'b0}}, q.unlocked};
    end

    assign cfg_out = q.regs;
endmodule

// File: rtl/xmem_wait_calc.sv
module xmem_wait_calc
    import xmem_pkg::*;
#(
    parameter int MAX_CYC = 16,
    parameter int CNT_W   = $clog2(MAX_CYC + 1)
) (
    input  logic [WAIT_W-1:0] code,
    output logic [CNT_W-1:0]  cycles
);
    int unsigned raw;

    always_comb begin
        raw    = 32'(code) + 32'd2;
        cycles = (raw > 32'(MAX_CYC)) ? CNT_W'(MAX_CYC) : CNT_W'(raw);
    end
endmodule

// File: rtl/xmem_seq.sv
module xmem_seq
    import xmem_pkg::*;
#(
    parameter int NUM_CS = 4,
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 5,
    parameter int CS_W   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [CS_W-1:0]   req_cs,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    input  cfg_t              sel_cfg,
    input  logic [CNT_W-1:0]  sel_cycles,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [1:0]        rsp_width,
    output logic [NUM_CS-1:0] mem_cs_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic              mem_sync,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata
);
    typedef struct packed {
        logic              busy;
        logic [CNT_W-1:0]  cnt;
        logic [CS_W-1:0]   cs;
        logic              write;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic              sync;
        logic              rsp_valid;
        logic              rsp_err;
        logic [DATA_W-1:0] rsp_rdata;
        logic [1:0]        rsp_width;
    } seq_t;

    seq_t d, q;

    always_comb begin
        d = q;
        d.rsp_valid = 1'b0;
        if (q.busy) begin
            if (q.cnt == '0) begin
                d.busy      = 1'b0;
                d.rsp_valid = 1'b1;
                d.rsp_err   = 1'b0;
                d.rsp_rdata = q.write ? '0 : mem_rdata;
            end else begin
                d.cnt = q.cnt - 1'b1;
            end
        end else if (req_valid) begin
            d.rsp_width = eff_width(sel_cfg.width);
            if (req_write && !sel_cfg.wen) begin
                d.rsp_valid = 1'b1;
                d.rsp_err   = 1'b1;
                d.rsp_rdata = '0;
            end else begin
                d.busy  = 1'b1;
                d.cnt   = sel_cycles - 1'b1;
                d.cs    = req_cs;
                d.write = req_write;
                d.addr  = req_addr;
                d.wdata = req_wdata;
                d.sync  = sel_cfg.sync;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
        assign mem_cs_n[i] = !(q.busy && (q.cs == CS_W'(i)));
    end

    assign req_ready = !q.busy;
    assign mem_oe_n  = !(q.busy && !q.write);
    assign mem_we_n  = !(q.busy && q.write);
    assign mem_sync  = q.busy && q.sync;
    assign mem_addr  = q.addr;
    assign mem_wdata = q.wdata;
    assign rsp_valid = q.rsp_valid;
    assign rsp_err   = q.rsp_err;
    assign rsp_rdata = q.rsp_rdata;
    assign rsp_width = q.rsp_width;
endmodule

// File: rtl/xmem_ctrl.sv
module xmem_ctrl
    import xmem_pkg::*;
#(
    parameter int NUM_CS   = 4,
    parameter int ADDR_W   = 16,
    parameter int DATA_W   = 32,
    parameter int MAX_CYC  = 16,
    parameter int CFG_AW   = 6,
    parameter int LOCK_OFF = 32,
    localparam int CS_W    = $clog2(NUM_CS),
    localparam int CNT_W   = $clog2(MAX_CYC + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [15:0]       cfg_wdata,
    output logic [15:0]       cfg_rdata,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [CS_W-1:0]   req_cs,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [1:0]        rsp_width,
    output logic [NUM_CS-1:0] mem_cs_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic              mem_sync,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata
);
    cfg_t [NUM_CS-1:0] cfg_all;
    cfg_t              sel_cfg;
    logic [CNT_W-1:0]  sel_cycles;

    xmem_cfg_bank #(
        .NUM_CS(NUM_CS), .CFG_AW(CFG_AW), .LOCK_OFF(LOCK_OFF)
    ) u_bank (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .cfg_out(cfg_all)
    );

    assign sel_cfg = cfg_all[req_cs];

    xmem_wait_calc #(.MAX_CYC(MAX_CYC), .CNT_W(CNT_W)) u_wait (
        .code(sel_cfg.wait_code), .cycles(sel_cycles)
    );

    xmem_seq #(
        .NUM_CS(NUM_CS), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
        .CNT_W(CNT_W), .CS_W(CS_W)
    ) u_seq (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write), .req_cs(req_cs),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
        .sel_cfg(sel_cfg), .sel_cycles(sel_cycles),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
        .rsp_width(rsp_width),
        .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
        .mem_sync(mem_sync), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata)
    );
endmodule

// File: rtl/xmem_ctrl_chk.sv
module xmem_ctrl_chk #(
    parameter int NUM_CS  = 4,
    parameter int ADDR_W  = 16,
    parameter int MAX_CYC = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NUM_CS-1:0] mem_cs_n,
    input logic              mem_oe_n,
    input logic              mem_we_n,
    input logic              mem_sync,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic              rsp_err
);
    localparam int RUN_W = $clog2(MAX_CYC + 2);
    logic [RUN_W-1:0] run_q;
    logic             idle;

    assign idle = &mem_cs_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (idle) begin
            run_q <= '0;
        end else if (run_q != '1) begin
            run_q <= run_q + 1'b1;
        end
    end

    a_r6_one_select: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~mem_cs_n));
    a_r6_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !(!mem_oe_n && !mem_we_n));
    a_r6_idle_strobes: assert property (@(posedge clk) disable iff (!rst_n)
        idle |-> (mem_oe_n && mem_we_n));
    a_r6_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
        (!idle && !$past(idle)) |-> $stable(mem_addr));
    a_r5_max_len: assert property (@(posedge clk) disable iff (!rst_n)
        run_q <= RUN_W'(MAX_CYC));
    a_r5_min_len: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(idle) |-> (run_q >= RUN_W'(2)));
    a_r7_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_err) |-> !$past(idle));
    a_r8_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_err) |-> $past(idle));
    a_r10_sync_idle: assert property (@(posedge clk) disable iff (!rst_n)
        idle |-> !mem_sync);
    a_r11_ready_idle: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> idle);
endmodule

bind xmem_ctrl xmem_ctrl_chk #(
    .NUM_CS(NUM_CS), .ADDR_W(ADDR_W), .MAX_CYC(MAX_CYC)
) u_chk (
    .clk(clk), .rst_n(rst_n), .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n),
    .mem_we_n(mem_we_n), .mem_sync(mem_sync), .mem_addr(mem_addr),
    .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_err(rsp_err)
);

// File: tb/sim_xmem_ctrl.sv
`timescale 1ns/1ps
module sim_xmem_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [5:0]  cfg_addr = '0;
    logic [15:0] cfg_wdata = '0;
    logic [15:0] cfg_rdata;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [1:0]  req_cs = '0;
    logic [15:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        req_ready;
    logic        rsp_valid;
    logic        rsp_err;
    logic [31:0] rsp_rdata;
    logic [1:0]  rsp_width;
    logic [3:0]  mem_cs_n;
    logic        mem_oe_n;
    logic        mem_we_n;
    logic        mem_sync;
    logic [15:0] mem_addr;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata = '0;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    logic [7:0] exp_cfg [4];
    bit         exp_unl;

    always #4 clk = ~clk;

    xmem_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .req_valid(req_valid), .req_write(req_write), .req_cs(req_cs),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
        .rsp_width(rsp_width), .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n),
        .mem_we_n(mem_we_n), .mem_sync(mem_sync), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    function automatic int exp_cycles(input logic [3:0] code);
        return (int'(code) + 2 > 16) ? 16 : int'(code) + 2;
    endfunction

    function automatic logic [1:0] exp_width(input logic [1:0] code);
        return (code == 2'b11) ? 2'b10 : code;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [5:0] a, input logic [15:0] v);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = v;
        @(negedge clk);
        cfg_wr = 1'b0;
        if (a == 6'h20) exp_unl = (v == 16'hA05F);
        else if (a[1:0] == 2'b00 && a < 6'h10 && exp_unl) exp_cfg[a[3:2]] = v[7:0];
    endtask

    task automatic cfg_check(input logic [5:0] a, input string tag);
        logic [15:0] e;
        @(negedge clk);
        cfg_addr = a;
        #1;
        e = (a == 6'h20) ? {15'h0, exp_unl} : {8'h00, exp_cfg[a[3:2]]};
        chk(tag, 32'(cfg_rdata), 32'(e));
    endtask

    task automatic access(input int cs, input bit wr, input logic [15:0] a,
                          input logic [31:0] wd, input bit poke);
        logic [7:0]  c;
        logic [31:0] rd;
        int          n;
        int          cnt;
        int          bad_sel;
        int          bad_dir;
        int          bad_hold;
        int          bad_sync;
        int          bad_busy;
        c  = exp_cfg[cs];
        n  = exp_cycles(c[7:4]);
        rd = $urandom;
        bad_sel = 0; bad_dir = 0; bad_hold = 0; bad_sync = 0; bad_busy = 0;
        @(negedge clk);
        chk("R11 ready when idle", 32'(req_ready), 32'd1);
        req_valid = 1'b1; req_write = wr; req_cs = 2'(cs);
        req_addr = a; req_wdata = wd; mem_rdata = rd;
        @(negedge clk);
        if (poke) begin
            req_cs = 2'(cs ^ 1); req_write = ~wr;
            req_addr = ~a; req_wdata = ~wd;
        end else begin
            req_valid = 1'b0;
        end
        if (wr && !c[2]) begin
            req_valid = 1'b0;
            chk("R8 gated write no select", 32'(mem_cs_n), 32'hF);
            chk("R8 gated write no strobe", 32'(mem_we_n), 32'd1);
            chk("R8 gated write response", 32'({rsp_valid, rsp_err}), 32'h3);
            chk("R9 width on error", 32'(rsp_width), 32'(exp_width(c[1:0])));
            return;
        end
        cnt = 0;
        while (mem_cs_n != 4'hF && cnt < 40) begin
            if (mem_cs_n != 4'(~(4'b0001 << cs))) bad_sel++;
            if (wr ? (mem_we_n !== 1'b0 || mem_oe_n !== 1'b1)
                   : (mem_oe_n !== 1'b0 || mem_we_n !== 1'b1)) bad_dir++;
            if (mem_addr !== a || (wr && mem_wdata !== wd)) bad_hold++;
            if (mem_sync !== c[3]) bad_sync++;
            if (req_ready !== 1'b0 || rsp_valid !== 1'b0) bad_busy++;
            cnt++;
            @(negedge clk);
        end
        req_valid = 1'b0;
        chk("R5 access length", 32'(cnt), 32'(n));
        chk("R6 only addressed select", 32'(bad_sel), 32'd0);
        chk("R6 strobe direction", 32'(bad_dir), 32'd0);
        chk("R6 address and data held", 32'(bad_hold), 32'd0);
        chk("R10 mode flag during strobe", 32'(bad_sync), 32'd0);
        chk("R10 mode flag idle", 32'(mem_sync), 32'd0);
        if (poke) chk("R11 busy ignores request", 32'(bad_busy), 32'd0);
        chk("R7 response pulse ok", 32'({rsp_valid, rsp_err}), 32'h2);
        chk("R7 read data", rsp_rdata, wr ? 32'h0 : rd);
        chk("R9 width report", 32'(rsp_width), 32'(exp_width(c[1:0])));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", n_chk, 0);
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        int op;
        void'($urandom(32'd20240611));
        for (int i = 0; i < 4; i++) exp_cfg[i] = 8'hF2;
        exp_unl = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1 selects idle", 32'(mem_cs_n), 32'hF);
        chk("R1 strobes idle", 32'({mem_oe_n, mem_we_n}), 32'h3);
        chk("R1 ready", 32'(req_ready), 32'd1);
        chk("R1 no response", 32'(rsp_valid), 32'd0);
        for (int i = 0; i < 4; i++) cfg_check(6'(i * 4), "R1 register reset value");
        cfg_check(6'h20, "R1 locked after reset");

        // R3: writes while locked are dropped, also after a wrong key
        cfg_write(6'h00, 16'h003C);
        cfg_check(6'h00, "R3 locked write ignored");
        cfg_write(6'h20, 16'h1234);
        cfg_check(6'h20, "R2 wrong key stays locked");
        cfg_write(6'h08, 16'h0011);
        cfg_check(6'h08, "R3 write after wrong key ignored");

        // R2 / R4: unlock, program, relock, unlock again
        cfg_write(6'h20, 16'hA05F);
        cfg_check(6'h20, "R2 key unlocks");
        cfg_write(6'h04, 16'hABCD);
        cfg_check(6'h04, "R4 upper bits read zero");
        cfg_write(6'h20, 16'hA05E);
        cfg_check(6'h20, "R2 other value relocks");
        cfg_write(6'h04, 16'h0000);
        cfg_check(6'h04, "R3 write after relock ignored");
        cfg_write(6'h20, 16'hA05F);
        cfg_write(6'h00, 16'h0004);
        cfg_write(6'h04, 16'h00E6);
        cfg_write(6'h08, 16'h00FF);
        cfg_write(6'h0C, 16'h00D1);
        for (int i = 0; i < 4; i++) cfg_check(6'(i * 4), "R4 readback");

        // directed accesses
        access(0, 1'b0, 16'h1000, 32'h0, 1'b0);          // R5 shortest, 2 cycles
        access(0, 1'b1, 16'h1004, 32'hCAFE0001, 1'b0);
        access(1, 1'b1, 16'h2222, 32'h5A5A5A5A, 1'b0);   // R5 code 14 -> 16
        access(2, 1'b0, 16'h3333, 32'h0, 1'b1);          // R5 code 15 -> 16, R9 code 11, R10, R11
        access(3, 1'b1, 16'h4444, 32'h12345678, 1'b0);   // R8 gated write
        access(3, 1'b0, 16'h4448, 32'h0, 1'b0);          // R8 read still proceeds, 15 cycles
        access(3, 1'b1, 16'h444C, 32'h9, 1'b1);          // R8 gated with pending request

        // constrained random mix
        for (int k = 0; k < 300; k++) begin
            op = $urandom_range(0, 9);
            if (op <= 1) begin
                cfg_write(6'(($urandom_range(0, 3)) * 4), 16'($urandom));
            end else if (op == 2) begin
                cfg_write(6'h20, ($urandom_range(0, 3) != 0) ? 16'hA05F : 16'($urandom));
            end else if (op == 3) begin
                if ($urandom_range(0, 1) == 1) cfg_check(6'h20, "R2 random lock state");
                else cfg_check(6'(($urandom_range(0, 3)) * 4), "R3 R4 random readback");
            end else begin
                access($urandom_range(0, 3), 1'($urandom), 16'($urandom), $urandom,
                       ($urandom_range(0, 7) == 0));
            end
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule